// File: doc/BRIEF.md
# Sparse Parallel-Prefix Adder/Subtractor

This block adds or subtracts two two's-complement operands in a single clock period. Its carries come from a sparse parallel-prefix network. A per-bit front end forms generate, propagate and half-sum (A XOR B) terms. When subtraction is selected, the second operand is inverted and the carry-in is forced high. The incoming carry is folded into the generate term of the lowest bit, so it travels through the tree like any other carry.

The tree runs log-depth prefix combining on the odd bit positions only. The even positions then pick up their carries in one last merge from the odd neighbour just below them, which is already resolved. This gives log2(W)+1 levels and about half the combining cells of a fully dense tree.

Each sum bit is its half-sum XOR the carry into that bit. The group generate of the whole word becomes the carry-out. A validity flag drops when the signed result overflows. The sum, carry-out and validity flag are registered on the rising clock edge.

Top module: `hc_addsub`

## Requirements
- R1: While `rst` is high at a rising edge, `sum_q`, `carry_q` and `correct_q` become 0 on that edge.
- R2: With `sub_en`=0, `sum_q` after the next rising edge equals (`op_a` + `op_b` + `carry_in`) mod 2^W.
- R3: With `sub_en`=0, `carry_q` equals bit W of the unsigned (W+1)-bit sum `op_a` + `op_b` + `carry_in`.
- R4: With `sub_en`=1, `sum_q` equals (`op_a` - `op_b`) mod 2^W. `carry_in` has no effect on any output in that mode.
- R5: With `sub_en`=1, `carry_q` is 1 exactly when `op_a` >= `op_b` taken as unsigned numbers, meaning no borrow.
- R6: `correct_q` is 0 when the signed result overflows and 1 otherwise. For example, -2^(W-1) + (-1) gives 0, and (2^(W-1)-1) + 2 gives 0.
- R7: A carry-in of 1 ripples through a run of W propagating bits. For example, all-ones + 0 + 1 gives sum 0 and carry 1.
- R8: Latency is exactly one clock. A new operation can be applied every cycle, and the outputs keep the previous result until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Carry into bit 0, used only when adding |
| sub_en | input | 1 | 1 selects op_a - op_b |
| sum_q | output | W | Registered sum or difference |
| carry_q | output | 1 | Registered carry out of the top bit |
| correct_q | output | 1 | Registered flag, 0 on signed overflow |

## Verification
All-ones-plus-carry operands force a carry to cross every prefix level and the final even-position merge, so a broken odd span or fill-in cell shows up as a wrong bit. The two signed wrap cases and their near misses separate overflow detection from plain carry-out, because their carry-out differs from their overflow. Subtraction with equal, greater and smaller operands checks the inversion and the forced carry-in, and repeating each with both carry-in values shows that the carry-in is ignored in that mode. Random operands in both modes, applied back to back, catch misrouted tree spans and stale registered results.

// File: rtl/hc_pkg.sv
package hc_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Combine a higher-significance group with the adjacent lower group.
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/hc_pg_front.sv
module hc_pg_front #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] g,
  output logic [W-1:0] p,
  output logic [W-1:0] hs,
  output logic         cin_eff
);
  logic [W-1:0] b_eff;

  assign b_eff   = b ^ {W{sub}};
  assign cin_eff = cin | sub;
  assign hs      = a ^ b_eff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      // fold the incoming carry into the lowest generate
      assign g[i] = (a[i] & b_eff[i]) | (hs[i] & cin_eff);
      assign p[i] = 1'b0;
    end else begin : g_rest
      assign g[i] = a[i] & b_eff[i];
      assign p[i] = hs[i];
    end
  end
endmodule

// File: rtl/hc_prefix_tree.sv
module hc_prefix_tree
  import hc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] g_in,
  input  logic [W-1:0] p_in,
  output logic [W-1:0] g_out
);
  localparam int LG   = $clog2(W);
  localparam int NLEV = LG + 2;

  gp_t lv [NLEV][W];

  for (genvar i = 0; i < W; i++) begin : g_seed
    assign lv[0][i] = '{g: g_in[i], p: p_in[i]};
  end

  // dense stages on odd positions only
  for (genvar s = 0; s < LG; s++) begin : g_stage
    localparam int D = 1 << s;
    for (genvar i = 0; i < W; i++) begin : g_cell
      if ((i % 2 == 1) && (i >= D)) begin : g_merge
        assign lv[s+1][i] = gp_merge(lv[s][i], lv[s][i-D]);
      end else begin : g_pass
        assign lv[s+1][i] = lv[s][i];
      end
    end
  end

  // fill-in stage for even positions from the resolved odd neighbour
  for (genvar i = 0; i < W; i++) begin : g_fill
    if ((i % 2 == 0) && (i >= 2)) begin : g_merge
      assign lv[LG+1][i] = gp_merge(lv[LG][i], lv[LG][i-1]);
    end else begin : g_pass
      assign lv[LG+1][i] = lv[LG][i];
    end
    assign g_out[i] = lv[LG+1][i].g;
  end
endmodule

// File: rtl/hc_sum_stage.sv
module hc_sum_stage #(
  parameter int W = 32
) (
  input  logic [W-1:0] hs,
  input  logic [W-1:0] grp_g,
  input  logic         cin_eff,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] c_into;

  assign c_into = {grp_g[W-2:0], cin_eff};
  assign sum    = hs ^ c_into;
  assign cout   = grp_g[W-1];
  assign ovf    = c_into[W-1] ^ grp_g[W-1];
endmodule

// File: rtl/hc_addsub.sv
module hc_addsub #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic         sub_en,
  output logic [W-1:0] sum_q,
  output logic         carry_q,
  output logic         correct_q
);
  logic [W-1:0] g_bit, p_bit, hs_bit, g_grp, sum_d;
  logic         cin_eff, cout_d, ovf_d;

  hc_pg_front #(.W(W)) u_front (
    .a(op_a), .b(op_b), .cin(carry_in), .sub(sub_en),
    .g(g_bit), .p(p_bit), .hs(hs_bit), .cin_eff(cin_eff)
  );

  hc_prefix_tree #(.W(W)) u_tree (
    .g_in(g_bit), .p_in(p_bit), .g_out(g_grp)
  );

  hc_sum_stage #(.W(W)) u_sum (
    .hs(hs_bit), .grp_g(g_grp), .cin_eff(cin_eff),
    .sum(sum_d), .cout(cout_d), .ovf(ovf_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      carry_q   <= 1'b0;
      correct_q <= 1'b0;
    end else begin
      sum_q     <= sum_d;
      carry_q   <= cout_d;
      correct_q <= ~ovf_d;
    end
  end
endmodule

// File: rtl/hc_addsub_chk.sv
module hc_addsub_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         carry_in,
  input logic         sub_en,
  input logic [W-1:0] sum_q,
  input logic         carry_q,
  input logic         correct_q
);
  logic [W-1:0] b_ref;
  logic         c_ref;
  logic [W:0]   wide_ref;
  logic         ovf_ref;

  assign b_ref    = sub_en ? ~op_b : op_b;
  assign c_ref    = sub_en ? 1'b1 : carry_in;
  assign wide_ref = {1'b0, op_a} + {1'b0, b_ref} + {{W{1'b0}}, c_ref};
  assign ovf_ref  = (op_a[W-1] == b_ref[W-1]) && (wide_ref[W-1] != op_a[W-1]);

  // R2 R4
  sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sum_q == $past(wide_ref[W-1:0]));

  // R3 R5
  carry_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> carry_q == $past(wide_ref[W]));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> correct_q == !$past(ovf_ref));

  // R4 R5
  self_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sub_en && (op_a == op_b))) |-> (sum_q == '0 && carry_q && correct_q));
endmodule

bind hc_addsub hc_addsub_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sub_en(sub_en), .sum_q(sum_q), .carry_q(carry_q), .correct_q(correct_q)
);

// File: tb/tb_hc_addsub.sv
module tb_hc_addsub;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         carry_in = 1'b0, sub_en = 1'b0;
  logic [W-1:0] sum_q;
  logic         carry_q, correct_q;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hc_addsub #(.W(W)) dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sub_en(sub_en), .sum_q(sum_q), .carry_q(carry_q), .correct_q(correct_q)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci, input logic sb);
    op_a = a; op_b = b; carry_in = ci; sub_en = sb;
  endtask

  // apply at a falling edge, check at the next falling edge
  task automatic run_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic ci, input logic sb);
    logic [W-1:0] be;
    logic         ce;
    logic [W:0]   wide;
    logic         ovf;
    be   = sb ? ~b : b;
    ce   = sb ? 1'b1 : ci;
    wide = {1'b0, a} + {1'b0, be} + {{W{1'b0}}, ce};
    ovf  = (a[W-1] == be[W-1]) && (wide[W-1] != a[W-1]);
    @(negedge clk);
    drive(a, b, ci, sb);
    @(negedge clk);
    chk({req, " sum"},     sum_q,                   wide[W-1:0]);
    chk({req, " carry"},   {{(W-1){1'b0}}, carry_q},   {{(W-1){1'b0}}, wide[W]});
    chk({req, " correct"}, {{(W-1){1'b0}}, correct_q}, {{(W-1){1'b0}}, ~ovf});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 sum",     sum_q, '0);
    chk("R1 carry",   {{(W-1){1'b0}}, carry_q},   '0);
    chk("R1 correct", {{(W-1){1'b0}}, correct_q}, '0);
    rst = 1'b0;
    run_op("R2", 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid sum",   sum_q, '0);
    chk("R1 mid carry", {{(W-1){1'b0}}, carry_q}, '0);
    rst = 1'b0;
  endtask

  task automatic t_add();
    run_op("R2", 32'd5, 32'd7, 1'b0, 1'b0);
    run_op("R2", 32'd5, 32'd7, 1'b1, 1'b0);
    run_op("R2", 32'h0000_0000, 32'hFFFF_FFFE, 1'b1, 1'b0);
    run_op("R3", 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
    run_op("R3", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 1'b0);
    run_op("R3", 32'h1234_5678, 32'h8765_4321, 1'b0, 1'b0);
  endtask

  task automatic t_sub();
    run_op("R4", 32'd100, 32'd42, 1'b0, 1'b1);
    run_op("R4 cin ignored", 32'd100, 32'd42, 1'b1, 1'b1);
    run_op("R5", 32'd3, 32'd9, 1'b0, 1'b1);
    run_op("R5 cin ignored", 32'd3, 32'd9, 1'b1, 1'b1);
    run_op("R5", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b1);
    run_op("R4", 32'h0000_0000, 32'h0000_0001, 1'b1, 1'b1);
  endtask

  task automatic t_overflow();
    run_op("R6", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0);
    chk("R6 flag low a", {{(W-1){1'b0}}, correct_q}, '0);
    run_op("R6", 32'h7FFF_FFFF, 32'h0000_0002, 1'b0, 1'b0);
    chk("R6 flag low b", {{(W-1){1'b0}}, correct_q}, '0);
    run_op("R6", 32'h7FFF_FFFF, 32'h0000_0000, 1'b0, 1'b0);
    run_op("R6", 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1);
    run_op("R6", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1);
    run_op("R6", 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
  endtask

  task automatic t_chain();
    run_op("R7", 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0);
    chk("R7 zero sum", sum_q, '0);
    run_op("R7", 32'h5555_5555, 32'hAAAA_AAAA, 1'b1, 1'b0);
    run_op("R7", 32'h0000_FFFF, 32'h0000_0000, 1'b1, 1'b0);
    run_op("R7", 32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    drive(32'd10, 32'd20, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 first", sum_q, 32'd30);
    drive(32'd1000, 32'd1, 1'b0, 1'b1);
    #1;
    chk("R8 held", sum_q, 32'd30);
    @(negedge clk);
    chk("R8 next", sum_q, 32'd999);
    for (int k = 0; k < 40; k++) begin
      run_op("R8 random", $urandom, $urandom, 1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_overflow();
    t_chain();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule